// File: doc/BRIEF.md
# Modulated Fractional Baud Tick Generator

This block derives serial bit timing from a source clock whose frequency is not an integer multiple of the wanted baud rate. Each bit period of a frame is counted out as an integer number of source cycles. That number is either the programmed divisor N or N+1. An 8-bit modulation word picks between the two for each bit period, so the average period falls between N and N+1. This keeps the baud error small even when the source clock is slow, for example a 32768 Hz crystal.

A serializer or deserializer sits next to the block. It pulses a frame-start strobe when a frame begins and then acts on each bit-boundary tick. The divisor and the modulation word are captured on that strobe. Bit period 0 is the start bit. The modulation index counts bit periods from the start bit and wraps every eight periods. The generator keeps producing ticks until the next frame-start strobe restarts it.

Top module: `baud_mod_gen`

## Requirements
- R1: After reset, and until the first frame-start strobe, `bitTick` stays low.
- R2: The k-th bit period of a frame (k counted from 0) lasts N + modWord[k mod 8] source cycles, where N is the effective divisor. Consecutive ticks are exactly that many cycles apart.
- R3: The first bit period after a strobe (the start bit) uses modWord bit 0, and later periods use the higher bits in rising order. With N=3 and modWord=0x4A the periods are 3,4,3,4,3,3,4,3.
- R4: The modulation index wraps after eight bit periods. The 9th and 10th periods of a frame use bits 0 and 1 again.
- R5: A programmed prescale value of 0, 1 or 2 acts as a divisor of 3.
- R6: `prescale` and `modWord` are sampled only on the cycle `frameStart` is high. Later changes have no effect on tick spacing until the next strobe.
- R7: A frame-start strobe in the middle of a period discards the partial count and resets the index to 0. The next tick follows N + modWord[0] cycles after the strobe edge.
- R8: The full 15-bit divisor range works. With prescale 0x7FFF and a stretched period, the interval is 32768 cycles.
- R9: `bitTick` is a one-cycle pulse. It is never high on two consecutive cycles, and it is low on the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock that the bit periods are counted in |
| rstN | input | 1 | Asynchronous active-low reset |
| prescale | input | 15 | Integer divisor N, sampled on frame start |
| modWord | input | 8 | Stretch selector, one bit per bit period, sampled on frame start |
| frameStart | input | 1 | One-cycle strobe that starts a frame at bit period 0 |
| bitTick | output | 1 | One-cycle pulse at the end of every bit period |

## Verification
The checker watches, on every cycle, that ticks are isolated pulses and that no tick follows a strobe directly. It also checks that the generator becomes active only through a strobe, and that the selected stretch bit holds still for the whole of a bit period. The exact length of each period depends on the captured divisor and modulation bits. The bench therefore measures every interval between ticks and compares it with N plus the selected bit. Those scenarios are also the only place where the following can be seen: the 0x4A sequence, the wrap after eight periods, clamping of small divisors, mid-frame restart, and insensitivity to input changes mid-frame.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture divisor, restart count
    logic run;   // generator active
  } ctlStrobes_t;
endpackage

// File: rtl/baudgen_dp.sv
module baudgen_dp
  import baudgen_pkg::*;
#(
  parameter int DIV_W   = 15,
  parameter int MIN_DIV = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic             stretch,
  input  logic [DIV_W-1:0] prescale,
  output logic             periodDone
);
  localparam int CNT_W = DIV_W + 1;
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] clampedDiv;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // R5: small divisors are raised to the minimum
  assign clampedDiv = (prescale < MIN_V) ? MIN_V : prescale;
  assign limit      = {1'b0, divReg} + CNT_W'(stretch);
  assign periodDone = strobes.run && (cnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= MIN_V;
      cnt    <= '0;
    end else if (strobes.load) begin
      divReg <= clampedDiv;
      cnt    <= CNT_W'(1);
    end else if (strobes.run) begin
      cnt <= periodDone ? CNT_W'(1) : cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/baudgen_ctrl.sv
module baudgen_ctrl
  import baudgen_pkg::*;
#(
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic [MOD_W-1:0] modWord,
  input  logic             periodDone,
  output ctlStrobes_t      strobes,
  output logic             stretch,
  output logic             bitTick
);
  localparam int IDX_W = (MOD_W > 1) ? $clog2(MOD_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MOD_W - 1);

  logic             running;
  logic [MOD_W-1:0] modReg;
  logic [IDX_W-1:0] modIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      modReg  <= '0;
      modIdx  <= '0;
    end else if (frameStart) begin
      running <= 1'b1;
      modReg  <= modWord;
      modIdx  <= '0;
    end else if (running && periodDone) begin
      modIdx <= (modIdx == LAST_IDX) ? '0 : modIdx + IDX_W'(1);
    end
  end

  assign strobes.load = frameStart;
  assign strobes.run  = running;
  assign stretch      = modReg[modIdx];
  assign bitTick      = running && periodDone;
endmodule

// File: rtl/baud_mod_gen.sv
module baud_mod_gen
  import baudgen_pkg::*;
#(
  parameter int DIV_W = 15,
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] prescale,
  input  logic [MOD_W-1:0] modWord,
  input  logic             frameStart,
  output logic             bitTick
);
  ctlStrobes_t strobes;
  logic        stretch;
  logic        periodDone;

  baudgen_ctrl #(.MOD_W(MOD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .modWord(modWord),
    .periodDone(periodDone), .strobes(strobes), .stretch(stretch),
    .bitTick(bitTick)
  );

  baudgen_dp #(.DIV_W(DIV_W), .MIN_DIV(3)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .stretch(stretch),
    .prescale(prescale), .periodDone(periodDone)
  );
endmodule

// File: rtl/baudgen_chk.sv
module baudgen_chk
  import baudgen_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        frameStart,
  input logic        bitTick,
  input ctlStrobes_t strobes,
  input logic        stretch
);
  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitTick);

  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !bitTick);

  // R1
  start_by_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.run) |-> $past(frameStart));

  // R6
  stretch_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && !bitTick && !frameStart) |=> $stable(stretch));
endmodule

bind baud_mod_gen baudgen_chk u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .bitTick(bitTick),
  .strobes(strobes), .stretch(stretch)
);

// File: tb/sim_baud_mod_gen.sv
module sim_baud_mod_gen;
  localparam int LIMIT = 40000;
  localparam int NVEC  = 5;
  // {prescale[14:0], modWord[7:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {15'd3,  8'h4A}, {15'h34, 8'h00}, {15'd5, 8'hFF},
    {15'd4,  8'h81}, {15'd7,  8'h55}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] prescale = 15'd3;
  logic [7:0]  modWord = 8'h00;
  logic        frameStart = 1'b0;
  logic        bitTick;

  int passCnt = 0;
  int failCnt = 0;
  int totalCnt = 0;

  always #4 clk = ~clk;

  baud_mod_gen u0 (
    .clk(clk), .rstN(rstN), .prescale(prescale), .modWord(modWord),
    .frameStart(frameStart), .bitTick(bitTick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expLen(input logic [14:0] p, input logic [7:0] m, input int k);
    int eff = (p < 15'd3) ? 3 : int'(p);
    return eff + int'(m[k % 8]);
  endfunction

  task automatic startFrame(input logic [14:0] p, input logic [7:0] m);
    @(negedge clk);
    prescale   = p;
    modWord    = m;
    frameStart = 1'b1;
  endtask

  task automatic nextInterval(output int len);
    int c = 0;
    do begin
      @(negedge clk);
      frameStart = 1'b0;
      c++;
    end while (!bitTick && c < LIMIT);
    len = c;
  endtask

  task automatic checkFrame(input logic [14:0] p, input logic [7:0] m,
                            input int n, input string req);
    int len;
    for (int k = 0; k < n; k++) begin
      nextInterval(len);
      check(len == expLen(p, m, k), req, len, expLen(p, m, k));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    totalCnt++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    int len;
    int ticks;

    // R1: quiet in reset and before the first strobe
    repeat (3) @(negedge clk);
    check(bitTick == 1'b0, "R1 in reset", int'(bitTick), 0);
    rstN = 1'b1;
    ticks = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (bitTick) ticks++;
    end
    check(ticks == 0, "R1 idle before strobe", ticks, 0);

    // R2 R3 R4: table of divisor/modulation pairs, ten periods each
    for (int v = 0; v < NVEC; v++) begin
      startFrame(VEC[v][22:8], VEC[v][7:0]);
      checkFrame(VEC[v][22:8], VEC[v][7:0], 10, "R2/R3/R4 table");
    end

    // R9: pulse is a single cycle
    startFrame(15'd3, 8'h00);
    nextInterval(len);
    @(negedge clk);
    check(bitTick == 1'b0, "R9 tick width", int'(bitTick), 0);
    @(negedge clk);
    check(bitTick == 1'b0, "R9 mid period", int'(bitTick), 0);
    @(negedge clk);
    check(bitTick == 1'b1, "R9 next tick", int'(bitTick), 1);

    // R6: inputs changed after the strobe are ignored
    startFrame(15'd4, 8'h00);
    nextInterval(len);
    check(len == 4, "R6 first", len, 4);
    prescale = 15'd9;
    modWord  = 8'hFF;
    for (int k = 0; k < 5; k++) begin
      nextInterval(len);
      check(len == 4, "R6 held", len, 4);
    end
    startFrame(15'd9, 8'hFF);
    checkFrame(15'd9, 8'hFF, 2, "R6 recaptured");

    // R7: restart in the middle of a period
    startFrame(15'd10, 8'h01);
    checkFrame(15'd10, 8'h01, 3, "R7 before restart");
    ticks = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (bitTick) ticks++;
    end
    check(ticks == 0, "R7 partial period", ticks, 0);
    startFrame(15'd10, 8'h01);
    nextInterval(len);
    check(len == 11, "R7 restart index 0", len, 11);
    nextInterval(len);
    check(len == 10, "R7 restart index 1", len, 10);

    // R5: clamp of small divisors
    startFrame(15'd0, 8'h02);
    checkFrame(15'd0, 8'h02, 3, "R5 prescale 0");
    startFrame(15'd1, 8'h00);
    checkFrame(15'd1, 8'h00, 2, "R5 prescale 1");
    startFrame(15'd2, 8'h00);
    checkFrame(15'd2, 8'h00, 2, "R5 prescale 2");

    // R8: top of the divisor range
    startFrame(15'h7FFF, 8'h01);
    nextInterval(len);
    check(len == 32768, "R8 stretched max", len, 32768);
    nextInterval(len);
    check(len == 32767, "R8 plain max", len, 32767);

    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule